// File: doc/BRIEF.md
# Strobed Input Handshake Channel

This block is the receive side of a strobed parallel input port. An external peripheral puts a byte on the port pins and pulses an active-low strobe. For as long as the strobe is seen low, the byte is copied into an input latch, and a buffer-full flag is raised back to the peripheral. When the strobe returns high, an interrupt request is raised to the CPU, but only if interrupts are enabled. The CPU then reads the port. The falling edge of that read drops the interrupt request. The rising edge of the read drops buffer-full, so the peripheral knows it may send again.

The interrupt enable is one flip-flop. Software writes it through a single-bit set/clear command aimed at the port C bit number that carries this channel's strobe line. A mode-selection write clears the enable and both handshake flags. A parameter selects the channel's pin map. Channel A uses bit 4 as strobe, bit 5 as buffer-full and bit 3 as interrupt. Channel B uses bits 2, 1 and 0 for the same roles.

The strobe and read inputs come from outside the clock domain. Each passes through a two-stage synchroniser before any edge is detected.

Top module: `shk_strobed_in`

## Requirements
- R1: While reset is asserted and after it is released, buffer-full, interrupt request and interrupt enable are all 0.
- R2: While the synchronised strobe is low, the latch loads the port pins on every clock. Buffer-full rises on the third clock edge after the strobe pin falls. While the strobe is high, the latch holds its value whatever the pins do.
- R3: Buffer-full falls on the third clock edge after the read input rises, and not before.
- R4: The interrupt request rises on the third clock edge after the strobe pin rises, if buffer-full and the enable are both 1. It stays 0 when the enable is 0.
- R5: The interrupt request falls on the third clock edge after the read input falls.
- R6: A bit set/clear command whose 3-bit bit number equals the channel's strobe bit (4 for channel A, 2 for channel B) writes its value bit into the enable on the next clock edge. Any other bit number leaves the enable unchanged. A clear also drops a pending interrupt request on that same edge.
- R7: A mode-selection write clears the enable, buffer-full and the interrupt request on the next clock edge. It overrides a bit set/clear command given in the same cycle.
- R8: A second strobe while buffer-full is still 1 overwrites the latch with the new byte, and buffer-full stays 1.
- R9: If the read input rises while the strobe is still low, buffer-full stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stb_n | input | 1 | Asynchronous active-low strobe from the peripheral |
| rd_n | input | 1 | Asynchronous active-low CPU read of this port, already qualified by select and address |
| port_in | input | DW | Port pins carrying the peripheral's byte |
| bsr_we | input | 1 | One-cycle pulse: port C bit set/clear command |
| bsr_bit | input | 3 | Bit number addressed by the set/clear command |
| bsr_val | input | 1 | 1 sets, 0 clears the addressed bit |
| mode_we | input | 1 | One-cycle pulse: mode-selection write |
| data_o | output | DW | Input latch contents |
| ibf_o | output | 1 | Buffer-full flag to the peripheral |
| intr_o | output | 1 | Interrupt request to the CPU |
| inte_o | output | 1 | Interrupt enable flip-flop |

## Verification
The asynchronous inputs each reach an edge detector after two synchroniser flops, and the handshake flags are registered after that. So buffer-full, the interrupt request and their clears are all due on the third rising edge after the pin changes. The bench drives pins on falling edges. It samples just after the second edge to confirm the old value, then just after the third to confirm the new one. Set/clear and mode writes are synchronous, so their effect is checked one edge after the pulse. Latch contents are checked only after the synchronised strobe has gone high, and are then re-checked after the pins change.

// File: rtl/shk_pkg.sv
package shk_pkg;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } shk_chan_e;

  // port C bit number of the strobe line; the enable is addressed through it
  function automatic logic [2:0] stb_bit(shk_chan_e ch);
    return (ch == CH_B) ? 3'd2 : 3'd4;
  endfunction

endpackage

// File: rtl/shk_rst_sync.sv
module shk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_r <= '0;
    else        chain_r <= {chain_r[STAGES-2:0], 1'b1};
  end

  assign rst_q = chain_r[STAGES-1];
endmodule

// File: rtl/shk_sync.sv
module shk_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_r;
  logic [STAGES-1:0] sh_n;

  always_comb sh_n = {sh_r[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_r <= {STAGES{RST_VAL}};
    else        sh_r <= sh_n;
  end

  assign q = sh_r[STAGES-1];
endmodule

// File: rtl/shk_inte.sv
module shk_inte #(
  parameter logic [2:0] STB_BIT = 3'd4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bsr_we,
  input  logic [2:0] bsr_bit,
  input  logic       bsr_val,
  input  logic       mode_we,
  output logic       inte,
  output logic       inte_clr
);
  logic inte_q, inte_n, hit, load;

  always_comb begin
    hit      = bsr_we && (bsr_bit == STB_BIT);
    load     = hit || mode_we;
    inte_n   = mode_we ? 1'b0 : bsr_val;
    inte_clr = mode_we || (hit && !bsr_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    inte_q <= 1'b0;
    else if (load) inte_q <= inte_n;
  end

  assign inte = inte_q;

  p_other_bits_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bsr_we && bsr_bit != STB_BIT && !mode_we) |=> $stable(inte_q));

  p_own_bit_written_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bsr_we && bsr_bit == STB_BIT && !mode_we) |=> (inte_q == $past(bsr_val)));
endmodule

// File: rtl/shk_core.sv
module shk_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_s,
  input  logic          rd_s,
  input  logic [DW-1:0] port_in,
  input  logic          inte,
  input  logic          inte_clr,
  input  logic          mode_we,
  output logic [DW-1:0] data,
  output logic          ibf,
  output logic          intr
);
  logic          stb_d, rd_d;
  logic [DW-1:0] data_q, data_n;
  logic          ibf_q, ibf_n, intr_q, intr_n;
  logic          stb_rise, rd_rise, rd_fall;

  always_comb begin
    stb_rise = stb_s && !stb_d;
    rd_rise  = rd_s && !rd_d;
    rd_fall  = !rd_s && rd_d;

    data_n = stb_s ? data_q : port_in;

    if (mode_we)     ibf_n = 1'b0;
    else if (!stb_s) ibf_n = 1'b1;
    else if (rd_rise) ibf_n = 1'b0;
    else             ibf_n = ibf_q;

    if (mode_we || inte_clr)            intr_n = 1'b0;
    else if (stb_rise && ibf_q && inte) intr_n = 1'b1;
    else if (rd_fall)                   intr_n = 1'b0;
    else                                intr_n = intr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_d  <= 1'b1;
      rd_d   <= 1'b1;
      ibf_q  <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      stb_d  <= stb_s;
      rd_d   <= rd_s;
      ibf_q  <= ibf_n;
      intr_q <= intr_n;
    end
  end

  // data latch: no reset, loaded only while the strobe is low
  always_ff @(posedge clk) begin
    if (!stb_s) data_q <= data_n;
  end

  assign data = data_q;
  assign ibf  = ibf_q;
  assign intr = intr_q;

  p_strobe_sets_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_s && !mode_we) |=> ibf_q);

  p_latch_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_s |=> $stable(data_q));

  p_intr_from_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_q) |-> $past(stb_rise && inte));

  p_read_fall_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && !stb_rise) |=> !intr_q);
endmodule

// File: rtl/shk_strobed_in.sv
module shk_strobed_in #(
  parameter shk_pkg::shk_chan_e CHAN = shk_pkg::CH_A,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_n,
  input  logic          rd_n,
  input  logic [DW-1:0] port_in,
  input  logic          bsr_we,
  input  logic [2:0]    bsr_bit,
  input  logic          bsr_val,
  input  logic          mode_we,
  output logic [DW-1:0] data_o,
  output logic          ibf_o,
  output logic          intr_o,
  output logic          inte_o
);
  localparam logic [2:0] STB_BIT = shk_pkg::stb_bit(CHAN);
  localparam int NSYNC = 2;

  logic             rst_q;
  logic [NSYNC-1:0] async_in, sync_out;
  logic             inte, inte_clr;

  assign async_in = {rd_n, stb_n};

  shk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    shk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_q), .d(async_in[g]), .q(sync_out[g])
    );
  end

  shk_inte #(.STB_BIT(STB_BIT)) u_inte (
    .clk(clk), .rst_n(rst_q), .bsr_we(bsr_we), .bsr_bit(bsr_bit),
    .bsr_val(bsr_val), .mode_we(mode_we), .inte(inte), .inte_clr(inte_clr)
  );

  shk_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_q), .stb_s(sync_out[0]), .rd_s(sync_out[1]),
    .port_in(port_in), .inte(inte), .inte_clr(inte_clr), .mode_we(mode_we),
    .data(data_o), .ibf(ibf_o), .intr(intr_o)
  );

  assign inte_o = inte;

  p_mode_clears_r7: assert property (@(posedge clk) disable iff (!rst_q)
    $past(mode_we) |-> (!inte_o && !ibf_o && !intr_o));

  p_intr_masked_r6: assert property (@(posedge clk) disable iff (!rst_q)
    intr_o |-> inte_o);

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_q |-> (!ibf_o && !intr_o && !inte_o));
endmodule

// File: tb/tb_shk_strobed_in.sv
module tb_shk_strobed_in;
  logic       clk = 1'b0;
  logic       rst_n, stb_n, rd_n, bsr_we, bsr_val, mode_we;
  logic [7:0] port_in;
  logic [2:0] bsr_bit;
  logic [7:0] da, db;
  logic       ibfa, ibfb, intra, intrb, intea, inteb;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  shk_strobed_in #(.CHAN(shk_pkg::CH_A)) dut (
    .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .rd_n(rd_n), .port_in(port_in),
    .bsr_we(bsr_we), .bsr_bit(bsr_bit), .bsr_val(bsr_val), .mode_we(mode_we),
    .data_o(da), .ibf_o(ibfa), .intr_o(intra), .inte_o(intea));

  shk_strobed_in #(.CHAN(shk_pkg::CH_B)) dut_b (
    .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .rd_n(rd_n), .port_in(port_in),
    .bsr_we(bsr_we), .bsr_bit(bsr_bit), .bsr_val(bsr_val), .mode_we(mode_we),
    .data_o(db), .ibf_o(ibfb), .intr_o(intrb), .inte_o(inteb));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic both(input string req, input logic a, input logic b, input int exp);
    chk({req, " chA"}, int'(a), exp);
    chk({req, " chB"}, int'(b), exp);
  endtask

  task automatic bsr(input int bitn, input logic v);
    bsr_we = 1'b1; bsr_bit = 3'(bitn); bsr_val = v;
    tick(1);
    bsr_we = 1'b0;
  endtask

  task automatic read_clear();
    rd_n = 1'b0; tick(3);
    rd_n = 1'b1; tick(3);
  endtask

  task automatic strobe(input logic [7:0] v);
    port_in = v; stb_n = 1'b0; tick(3);
    stb_n = 1'b1; tick(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stb_n = 1'b1; rd_n = 1'b1; port_in = 8'h00;
    bsr_we = 1'b0; bsr_bit = 3'd0; bsr_val = 1'b0; mode_we = 1'b0;
    tick(3);
    both("R1 ibf in reset", ibfa, ibfb, 0);
    both("R1 intr in reset", intra, intrb, 0);
    rst_n = 1'b1;
    tick(4);
    both("R1 ibf after reset", ibfa, ibfb, 0);
    both("R1 intr after reset", intra, intrb, 0);
    both("R1 inte after reset", intea, inteb, 0);

    // R6: sweep every bit number; only the strobe bit reaches the enable
    for (int b = 0; b < 8; b++) begin
      bsr(b, 1'b1);
      chk("R6 set chA", int'(intea), int'(b == 4));
      chk("R6 set chB", int'(inteb), int'(b == 2));
      bsr(b, 1'b0);
      both("R6 clear", intea, inteb, 0);
    end

    bsr(4, 1'b1);
    bsr(2, 1'b1);

    // R2..R5 sweep over every byte value
    for (int v = 0; v < 256; v++) begin
      port_in = 8'(v); stb_n = 1'b0;
      tick(2);
      both("R2 ibf not before edge 3", ibfa, ibfb, 0);
      tick(1);
      both("R2 ibf on edge 3", ibfa, ibfb, 1);
      tick(2);
      stb_n = 1'b1;
      tick(2);
      both("R4 intr not before edge 3", intra, intrb, 0);
      tick(1);
      both("R4 intr on edge 3", intra, intrb, 1);
      chk("R2 latch chA", int'(da), v);
      chk("R2 latch chB", int'(db), v);
      port_in = ~8'(v);
      tick(3);
      chk("R2 hold chA", int'(da), v);
      chk("R2 hold chB", int'(db), v);
      rd_n = 1'b0;
      tick(2);
      both("R5 intr not before edge 3", intra, intrb, 1);
      tick(1);
      both("R5 intr on edge 3", intra, intrb, 0);
      both("R3 ibf held during read", ibfa, ibfb, 1);
      rd_n = 1'b1;
      tick(2);
      both("R3 ibf not before edge 3", ibfa, ibfb, 1);
      tick(1);
      both("R3 ibf on edge 3", ibfa, ibfb, 0);
    end

    // R4: enable low, no interrupt
    bsr(4, 1'b0);
    bsr(2, 1'b0);
    strobe(8'h3C);
    tick(2);
    both("R4 ibf with enable low", ibfa, ibfb, 1);
    both("R4 no intr with enable low", intra, intrb, 0);
    read_clear();

    // R8: overwrite while full
    bsr(4, 1'b1);
    bsr(2, 1'b1);
    strobe(8'h5A);
    strobe(8'hC3);
    chk("R8 overwrite chA", int'(da), 8'hC3);
    chk("R8 overwrite chB", int'(db), 8'hC3);
    both("R8 ibf stays", ibfa, ibfb, 1);
    both("R8 intr", intra, intrb, 1);

    // R6: clearing the enable drops a pending request, per channel
    bsr(4, 1'b0);
    chk("R6 clear drops intr chA", int'(intra), 0);
    chk("R6 other channel keeps intr chB", int'(intrb), 1);
    bsr(2, 1'b0);
    chk("R6 clear drops intr chB", int'(intrb), 0);
    read_clear();
    both("R3 ibf cleared", ibfa, ibfb, 0);

    // R9: read rising while strobe still low
    port_in = 8'h81; stb_n = 1'b0;
    tick(4);
    read_clear();
    both("R9 ibf kept while strobe low", ibfa, ibfb, 1);
    stb_n = 1'b1; tick(3);
    read_clear();
    both("R9 ibf cleared after release", ibfa, ibfb, 0);

    // R7: mode write clears everything and overrides a same-cycle set
    bsr(4, 1'b1);
    bsr(2, 1'b1);
    strobe(8'h99);
    both("R7 precondition intr", intra, intrb, 1);
    mode_we = 1'b1; bsr_we = 1'b1; bsr_bit = 3'd4; bsr_val = 1'b1;
    tick(1);
    mode_we = 1'b0; bsr_we = 1'b0;
    both("R7 inte cleared", intea, inteb, 0);
    both("R7 ibf cleared", ibfa, ibfb, 0);
    both("R7 intr cleared", intra, intrb, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule